// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the receive and transmit timing strobes of a UART from the core clock. The core clock first goes through a power-of-two prescaler set by a 3-bit exponent. It then goes through a fractional stage whose ratio is 1 + F/64, where F is a 6-bit fraction code. The result is a 16x oversampling strobe. One strobe in every sixteen of those is also flagged as a bit-rate strobe. With both stages combined, one bit lasts 2^DIV·(64+F)/4 core cycles on average. The bit rate is therefore 4·fcore / (2^DIV·(64+F)). This lets the block reach rates such as 115200 bit/s from clocks that a plain integer divider cannot serve.

Two write ports load the configuration. The control byte holds an enable flag and the prescale exponent. The fraction port holds F. Any write restarts all three counting stages from zero. When the enable is clear, the receive and transmit strobes come unchanged from two external legacy timer strobes, and the generator stays idle. When the enable is set, the generator drives both strobes and the legacy inputs are ignored. Every output is a one-cycle pulse in the core clock domain. No output is a derived clock.

No data moves through the block, so there is no valid/ready handshake. The configuration writes are single-cycle strobes and can never be refused.

Top module: `frac_baud_gen`

## Requirements
- R1: Control byte bit 7 is the enable. When it is clear, `rx_tick` equals `legacy_rx_tick` and `tx_tick` equals `legacy_tx_tick` in the same cycle. When it is set, both equal `os_tick`.
- R2: While the enable is set, `legacy_rx_tick` and `legacy_tx_tick` have no effect on any output.
- R3: Control byte bits 2:0 hold DIV, and the prescaler divides the core clock by 2^DIV. Control byte bits 6:3 have no effect.
- R4: Over any 4·k whole bit periods, measured from one `bit_tick` to a later one, the number of core cycles is exactly k·2^DIV·(64+F). F is the 6-bit value on `fd_wdata`.
- R5: `bit_tick` is only ever high together with `os_tick`. Exactly 16 `os_tick` pulses occur per bit period, counting the one that carries the `bit_tick`.
- R6: DIV=3 with F=9 gives 146 core cycles per bit. At a 16777216 Hz core clock that is 114912 bit/s, which is within 0.8% of 115200.
- R7: A write on either configuration port clears the prescaler, the fractional accumulator and the divide-by-16 counter. There is no strobe in the cycle after the write. With DIV=0 and F=0, the first `bit_tick` comes 16 cycles after the write edge.
- R8: Strobes last one cycle. With DIV of 1 or more, `os_tick` is never high in two adjacent cycles.
- R9: After reset the enable is clear, DIV=0, F=0, and `os_tick` and `bit_tick` are low.
- R10: While the enable is clear, `os_tick` and `bit_tick` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte: bit 7 enable, bits 2:0 DIV, bits 6:3 ignored |
| fd_we | input | 1 | Write strobe for the fraction code |
| fd_wdata | input | 6 | Fraction code F (ratio 1 + F/64) |
| legacy_rx_tick | input | 1 | Receive strobe from the legacy timer path |
| legacy_tx_tick | input | 1 | Transmit strobe from the legacy timer path |
| os_tick | output | 1 | 16x oversampling strobe from this generator |
| bit_tick | output | 1 | Bit-rate strobe, every 16th `os_tick` |
| rx_tick | output | 1 | Selected receive oversampling strobe |
| tx_tick | output | 1 | Selected transmit oversampling strobe |

## Verification
The bound checker watches several properties on every cycle:
- `bit_tick` only coincides with `os_tick`, and 16 oversampling pulses occur per bit.
- The fractional accumulator stays below 64+F.
- Both strobes stay quiet while the block is disabled and in the cycle after any configuration write.
- There are no back-to-back oversampling pulses once DIV is at least 1.

Only the bench scenarios can show the long-run averages: the exact cycle totals per group of four bits, the worked 115200 case, the restart latency after a write, the legacy passthrough, and that the reserved control bits leave the rate untouched.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  // Default field widths of the configuration interface
  localparam int DEF_DIV_W    = 3;
  localparam int DEF_FD_W     = 6;
  localparam int DEF_CTRL_W   = 8;
  localparam int DEF_OS_RATIO = 16;

  // Source feeding the UART receive/transmit strobes
  typedef enum logic {
    SRC_LEGACY = 1'b0,
    SRC_FRAC   = 1'b1
  } tick_src_e;

  // Receive and transmit channel indices of the output selector
  localparam int CH_RX = 0;
  localparam int CH_TX = 1;
  localparam int N_CH  = 2;

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  // Longest period is 2^(2^DIV_W - 1) cycles
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  // Low DIV bits of the counter set: the counter has completed 2^DIV cycles
  always_comb begin
    mask = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(div)) mask[i] = 1'b1;
    end
  end

  assign tick = !clr && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
  parameter int FD_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            in_tick,
  input  logic [FD_W-1:0] fd,
  output logic            emit,
  output logic [FD_W+1:0] acc
);

  localparam int ACC_W = FD_W + 2;
  localparam logic [ACC_W-1:0] MODULUS = ACC_W'(1 << FD_W);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] limit;
  logic [ACC_W-1:0] sum;

  // Each input tick adds 2^FD_W; one output per (2^FD_W + fd) added
  assign limit = MODULUS + ACC_W'(fd);
  assign sum   = acc_q + MODULUS;
  assign emit  = in_tick && !clr && (sum >= limit);
  assign acc   = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc_q <= '0;
    else if (in_tick) acc_q <= emit ? (sum - limit) : sum;
  end

endmodule

// File: rtl/baud_os_div.sv
module baud_os_div #(
  parameter int OS_RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic os_in,
  output logic os_q,
  output logic bit_q
);

  localparam int OS_W = $clog2(OS_RATIO);
  localparam logic [OS_W-1:0] LAST = OS_W'(OS_RATIO - 1);

  logic [OS_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
      os_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      os_q  <= os_in;
      bit_q <= os_in && (cnt_q == LAST);
      if (os_in) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int DIV_W    = DEF_DIV_W,
  parameter int FD_W     = DEF_FD_W,
  parameter int CTRL_W   = DEF_CTRL_W,
  parameter int OS_RATIO = DEF_OS_RATIO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              fd_we,
  input  logic [FD_W-1:0]   fd_wdata,
  input  logic              legacy_rx_tick,
  input  logic              legacy_tx_tick,
  output logic              os_tick,
  output logic              bit_tick,
  output logic              rx_tick,
  output logic              tx_tick
);

  localparam int EN_BIT = CTRL_W - 1;

  logic             en_q;
  logic [DIV_W-1:0] div_q;
  logic [FD_W-1:0]  fd_q;
  logic             clr_all;
  logic             pre_tick;
  logic             frac_emit;
  logic [FD_W+1:0]  acc_val;
  tick_src_e        src;
  logic [N_CH-1:0]  legacy_vec;
  logic [N_CH-1:0]  out_vec;
  logic             unused_rsvd;

  assign unused_rsvd = ^ctrl_wdata[EN_BIT-1:DIV_W];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
      fd_q  <= '0;
    end else begin
      if (ctrl_we) begin
        en_q  <= ctrl_wdata[EN_BIT];
        div_q <= ctrl_wdata[DIV_W-1:0];
      end
      if (fd_we) fd_q <= fd_wdata;
    end
  end

  // Any write restarts the chain; a disabled generator is held cleared
  assign clr_all = ctrl_we || fd_we || !en_q;

  baud_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_all),
    .div   (div_q),
    .tick  (pre_tick)
  );

  baud_frac_acc #(.FD_W(FD_W)) u_frac (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_all),
    .in_tick (pre_tick),
    .fd      (fd_q),
    .emit    (frac_emit),
    .acc     (acc_val)
  );

  baud_os_div #(.OS_RATIO(OS_RATIO)) u_os (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_all),
    .os_in (frac_emit),
    .os_q  (os_tick),
    .bit_q (bit_tick)
  );

  // Output selector, one leg per UART direction
  assign src = en_q ? SRC_FRAC : SRC_LEGACY;
  assign legacy_vec[CH_RX] = legacy_rx_tick;
  assign legacy_vec[CH_TX] = legacy_tx_tick;

  for (genvar g = 0; g < N_CH; g++) begin : g_sel
    assign out_vec[g] = (src == SRC_FRAC) ? os_tick : legacy_vec[g];
  end

  assign rx_tick = out_vec[CH_RX];
  assign tx_tick = out_vec[CH_TX];

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int DIV_W    = 3,
  parameter int FD_W     = 6,
  parameter int OS_RATIO = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_we,
  input logic             fd_we,
  input logic             en_q,
  input logic [DIV_W-1:0] div_q,
  input logic [FD_W-1:0]  fd_q,
  input logic [FD_W+1:0]  acc_val,
  input logic             os_tick,
  input logic             bit_tick
);

  localparam int SEEN_W = $clog2(OS_RATIO) + 1;

  logic [SEEN_W-1:0] os_seen;

  // Oversampling pulses since the last bit pulse or restart
  always_ff @(posedge clk) begin
    if (!rst_n || ctrl_we || fd_we || !en_q) os_seen <= '0;
    else if (bit_tick)                       os_seen <= '0;
    else if (os_tick)                        os_seen <= os_seen + 1'b1;
  end

  a_r5_bit_with_os: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  a_r5_sixteen_per_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (os_seen == SEEN_W'(OS_RATIO - 1)));

  a_r4_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc_val < ((FD_W+2)'(1 << FD_W) + (FD_W+2)'(fd_q)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!os_tick && !bit_tick));

  a_r7_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we || fd_we) |=> (!os_tick && !bit_tick));

  a_r8_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && div_q != '0 && !ctrl_we && !fd_we) |=> !os_tick);

endmodule

bind frac_baud_gen frac_baud_gen_chk #(
  .DIV_W    (DIV_W),
  .FD_W     (FD_W),
  .OS_RATIO (OS_RATIO)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_we  (ctrl_we),
  .fd_we    (fd_we),
  .en_q     (en_q),
  .div_q    (div_q),
  .fd_q     (fd_q),
  .acc_val  (acc_val),
  .os_tick  (os_tick),
  .bit_tick (bit_tick)
);

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/1ps
module frac_baud_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       fd_we = 1'b0;
  logic [5:0] fd_wdata = 6'h00;
  logic       legacy_rx_tick = 1'b0;
  logic       legacy_tx_tick = 1'b0;
  logic       os_tick, bit_tick, rx_tick, tx_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  localparam int WATCHDOG = 150000;

  // {div[3], fd[6], bits[8], expected cycles per 4 bits[16]}
  localparam logic [32:0] VEC [8] = '{
    {3'd3, 6'd9,  8'd16, 16'd584},
    {3'd0, 6'd0,  8'd16, 16'd64},
    {3'd0, 6'd63, 8'd16, 16'd127},
    {3'd1, 6'd37, 8'd8,  16'd202},
    {3'd2, 6'd20, 8'd8,  16'd336},
    {3'd5, 6'd50, 8'd4,  16'd3648},
    {3'd7, 6'd63, 8'd4,  16'd16256},
    {3'd4, 6'd1,  8'd8,  16'd1040}
  };

  frac_baud_gen uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl_we        (ctrl_we),
    .ctrl_wdata     (ctrl_wdata),
    .fd_we          (fd_we),
    .fd_wdata       (fd_wdata),
    .legacy_rx_tick (legacy_rx_tick),
    .legacy_tx_tick (legacy_tx_tick),
    .os_tick        (os_tick),
    .bit_tick       (bit_tick),
    .rx_tick        (rx_tick),
    .tx_tick        (tx_tick)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WATCHDOG);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wdata = v;
    ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_fd(input logic [5:0] v);
    fd_wdata = v;
    fd_we = 1'b1;
    @(negedge clk);
    fd_we = 1'b0;
  endtask

  // Cycles spanned by nbits bit periods, strobe to strobe
  task automatic measure(input int div, input int fd, input int nbits,
                         input logic [3:0] rsvd, output longint total);
    int seen;
    wr_fd(6'(fd));
    wr_ctrl({1'b1, rsvd, 3'(div)});
    while (!bit_tick) @(negedge clk);
    total = 0;
    seen = 0;
    while (seen < nbits) begin
      @(negedge clk);
      total = total + 1;
      if (bit_tick) seen = seen + 1;
    end
  endtask

  initial begin
    longint total;
    longint rate;
    int k;
    int cnt;
    int bad;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    check("R9 os_tick after reset", os_tick, 0);
    check("R9 bit_tick after reset", bit_tick, 0);

    // R1: disabled, legacy strobes pass straight through
    legacy_rx_tick = 1'b1; legacy_tx_tick = 1'b0; #1;
    check("R1 rx follows legacy", rx_tick, 1);
    check("R1 tx follows legacy", tx_tick, 0);
    legacy_rx_tick = 1'b0; legacy_tx_tick = 1'b1; #1;
    check("R1 rx follows legacy (swap)", rx_tick, 0);
    check("R1 tx follows legacy (swap)", tx_tick, 1);
    legacy_tx_tick = 1'b0;

    // R10: disabled generator stays quiet
    wr_fd(6'd0);
    wr_ctrl(8'h00);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (os_tick || bit_tick) cnt = cnt + 1;
    end
    check("R10 strobes while disabled", cnt, 0);

    // R4/R3: table of rates, exact totals over groups of four bits
    for (int v = 0; v < 8; v++) begin
      measure(int'(VEC[v][32:30]), int'(VEC[v][29:24]), int'(VEC[v][23:16]),
              4'h0, total);
      check($sformatf("R4 cycles div=%0d fd=%0d", VEC[v][32:30], VEC[v][29:24]),
            total, longint'(VEC[v][15:0]) * longint'(VEC[v][23:16]) / 4);
      if (v == 0) begin
        // R6: worked case at a 16777216 Hz core clock
        rate = (64'd16777216 * 16) / total;
        check("R6 bit rate", rate, 114912);
        check("R6 within 0.8% of 115200",
              ((rate > 115200 ? rate - 115200 : 115200 - rate) * 1000 <= 115200 * 8), 1);
      end
    end

    // R3: reserved control bits leave the rate untouched
    measure(2, 20, 8, 4'hF, total);
    check("R3 reserved bits set, div=2 fd=20", total, 336 * 2);
    measure(6, 0, 4, 4'h5, total);
    check("R3 prescale 2^6, fd=0", total, 64 * 64);

    // R7: restart latency after a control write while running
    measure(0, 0, 4, 4'h0, total);
    repeat (5) @(negedge clk);
    wr_ctrl(8'h80);
    check("R7 no os strobe after ctrl write", os_tick, 0);
    k = 0;
    while (!bit_tick && k < 100) begin @(negedge clk); k = k + 1; end
    check("R7 first bit strobe after ctrl write", k, 16);
    repeat (7) @(negedge clk);
    wr_fd(6'd0);
    check("R7 no bit strobe after fd write", bit_tick, 0);
    k = 0;
    while (!bit_tick && k < 100) begin @(negedge clk); k = k + 1; end
    check("R7 first bit strobe after fd write", k, 16);

    // R2 and R8: DIV=1, F=0 gives an oversampling strobe every other cycle
    wr_fd(6'd0);
    wr_ctrl(8'h81);
    legacy_rx_tick = 1'b1; legacy_tx_tick = 1'b1;
    cnt = 0; bad = 0; k = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (rx_tick !== os_tick || tx_tick !== os_tick) bad = bad + 1;
      if (os_tick && k == 1) bad = bad + 100;
      k = os_tick ? 1 : 0;
      if (os_tick) cnt = cnt + 1;
    end
    check("R2 legacy ignored while enabled", bad % 100, 0);
    check("R8 no adjacent os strobes", bad / 100, 0);
    check("R8 os strobes in 64 cycles", cnt, 32);
    legacy_rx_tick = 1'b0; legacy_tx_tick = 1'b0;

    // R5: sixteen oversampling pulses per bit, bit pulse rides on one
    measure(2, 30, 1, 4'h0, total);
    cnt = 0; bad = 0;
    for (int b = 0; b < 3; b++) begin
      k = 0;
      do begin
        @(negedge clk);
        if (os_tick) k = k + 1;
        if (bit_tick && !os_tick) bad = bad + 1;
      end while (!bit_tick);
      if (k != 16) cnt = cnt + 1;
    end
    check("R5 periods without 16 os strobes", cnt, 0);
    check("R5 bit strobe without os strobe", bad, 0);

    // R1/R10: disabling returns control to the legacy path
    wr_ctrl(8'h03);
    legacy_rx_tick = 1'b1; #1;
    check("R1 rx follows legacy after disable", rx_tick, 1);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (os_tick || bit_tick) cnt = cnt + 1;
    end
    check("R10 strobes after disable", cnt, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule